// File: doc/BRIEF.md
# Decision Feedback Equalizer with Recursive Tail Cancellation

This block equalizes a stream of signed receiver samples taken from a smooth channel, one whose inter-symbol interference after the first post-cursor dies away roughly exponentially. The strong first post-cursor is removed by one feedback tap that weights the previous decision. Everything from the second post-cursor onward is removed by a single first-order low-pass recursive filter driven by past decisions, so a long chain of feedback taps is not needed. The approach suits channels with few reflections. Channels with many reflections do not follow the exponential model.

For each accepted sample the block subtracts both ISI estimates and slices the result to a binary decision. The equalized value and the decision leave through a registered valid/ready output one cycle later. The first-tap weight, the tail amplitude and the tail decay shift are plain control inputs. They are read only in the cycle a sample is accepted. The input side applies back-pressure: a new sample is taken only when the output register is empty, or is being emptied in that same cycle.

Top module: `dfe_iir_eq`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0, `in_ready` is 1, the tail state is 0 and the stored previous decision is +1. The first sample after reset is therefore equalized as `y - w1`.
- R2: A decision of +1 is encoded as bit 1 and a decision of -1 as bit 0. The equalized value is z = y - w1·d_prev - s, where y is the sample, w1 is the signed two's complement first-tap weight, d_prev is the decision for the previous accepted sample, and s is the current tail state.
- R3: `out_bit` is 1 exactly when the equalized value z is greater than or equal to zero.
- R4: After a sample is accepted, the tail state updates as s ← s − (s >>> K) + ((A·d_prev) >>> K). Here A is the unsigned tail amplitude and d_prev is the decision made before that sample. The tail term used on a sample therefore starts with the decision two samples earlier.
- R5: `>>>` is a floor arithmetic right shift by K. K equals `cfg_shift` for codes 1 to 7, and code 0 acts as 1.
- R6: The tail state is a signed SW-bit value that saturates at its most positive and most negative values instead of wrapping.
- R7: A sample accepted on a clock edge (`in_valid` and `in_ready` both high) produces `out_valid` = 1 with its `out_eq` and `out_bit` right after that edge. `out_valid` drops after an edge where `out_ready` was high and no sample was accepted.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_eq` and `out_bit` hold their values.
- R9: The tail state and the stored decision change only when a sample is accepted. Control inputs applied while no sample is accepted have no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | DW | Signed receiver sample |
| cfg_w1 | input | WW | Signed first-tap weight |
| cfg_amp | input | WW | Unsigned tail amplitude |
| cfg_shift | input | 3 | Tail decay shift code |
| out_valid | output | 1 | Output result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_eq | output | DW+2 | Signed equalized value |
| out_bit | output | 1 | Decision, 1 for +1 |

## Verification
Every result is due one clock edge after the handshake that accepts its sample. The tail state feeds the second sample after the decision that drove it. The bench drives inputs at the falling edge and updates its reference model only when it sees the handshake at that edge. At the next falling edge it compares `out_valid`, `out_eq` and `out_bit`. During stalls it compares again to confirm the output holds. Directed cases check the first sample after reset, the decay code 0, a tail run into saturation with hand-worked values, and configuration changes while idle.

// File: rtl/dfe_iir_pkg.sv
package dfe_iir_pkg;
  typedef logic [2:0] shift_code_t;

  // decay code 0 behaves as a shift of one
  function automatic shift_code_t eff_shift(input shift_code_t code);
    return (code == 3'd0) ? 3'd1 : code;
  endfunction
endpackage

// File: rtl/dfe_iir_tail.sv
module dfe_iir_tail
  import dfe_iir_pkg::*;
#(
  parameter int WW = 8,
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 prev_bit,
  input  logic [WW-1:0]        amp,
  input  shift_code_t          shift,
  output logic signed [SW-1:0] state
);
  localparam int XW = ((WW > SW) ? WW : SW) + 3;
  localparam logic signed [XW-1:0] SMAX = XW'((2 ** (SW - 1)) - 1);
  localparam logic signed [XW-1:0] SMIN = -SMAX - XW'(1);

  logic signed [XW-1:0] s_ext, t_pos, t_ext, nxt;
  shift_code_t          k;

  always_comb begin
    k     = eff_shift(shift);
    s_ext = {{(XW - SW){state[SW-1]}}, state};
    t_pos = {{(XW - WW){1'b0}}, amp};
    t_ext = prev_bit ? t_pos : -t_pos;
    nxt   = s_ext - (s_ext >>> k) + (t_ext >>> k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          state <= '0;
    else if (step) begin
      if (nxt > SMAX)      state <= SMAX[SW-1:0];
      else if (nxt < SMIN) state <= SMIN[SW-1:0];
      else                 state <= nxt[SW-1:0];
    end
  end

  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
  a_r4_zero_amp_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (step && amp == '0 && state == '0) |=> state == '0);
endmodule

// File: rtl/dfe_sum_slice.sv
module dfe_sum_slice #(
  parameter int DW = 10,
  parameter int WW = 8,
  parameter int SW = 8,
  parameter int ZW = 12
) (
  input  logic signed [DW-1:0] sample,
  input  logic signed [WW-1:0] w1,
  input  logic signed [SW-1:0] tail,
  input  logic                 prev_bit,
  output logic signed [ZW-1:0] z,
  output logic                 dec
);
  logic signed [ZW-1:0] y_ext, w_ext, s_ext, h1;

  always_comb begin
    y_ext = {{(ZW - DW){sample[DW-1]}}, sample};
    w_ext = {{(ZW - WW){w1[WW-1]}}, w1};
    s_ext = {{(ZW - SW){tail[SW-1]}}, tail};
    h1    = prev_bit ? w_ext : -w_ext;
    z     = y_ext - h1 - s_ext;
    dec   = ~z[ZW-1];
  end
endmodule

// File: rtl/dfe_iir_eq.sv
module dfe_iir_eq
  import dfe_iir_pkg::*;
#(
  parameter int DW = 10,
  parameter int WW = 8,
  parameter int SW = 8,
  localparam int MW = (DW > WW) ? ((DW > SW) ? DW : SW) : ((WW > SW) ? WW : SW),
  localparam int ZW = MW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_sample,
  input  logic signed [WW-1:0] cfg_w1,
  input  logic [WW-1:0]        cfg_amp,
  input  logic [2:0]           cfg_shift,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [ZW-1:0] out_eq,
  output logic                 out_bit
);
  logic                 accept;
  logic                 hist_bit;
  logic signed [SW-1:0] tail_s;
  logic signed [ZW-1:0] z_c;
  logic                 dec_c;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dfe_sum_slice #(.DW(DW), .WW(WW), .SW(SW), .ZW(ZW)) u_slice (
    .sample(in_sample), .w1(cfg_w1), .tail(tail_s), .prev_bit(hist_bit),
    .z(z_c), .dec(dec_c)
  );

  dfe_iir_tail #(.WW(WW), .SW(SW)) u_tail (
    .clk(clk), .rst_n(rst_n), .step(accept), .prev_bit(hist_bit),
    .amp(cfg_amp), .shift(cfg_shift), .state(tail_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) hist_bit <= 1'b1;
    else if (accept) hist_bit <= dec_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_eq    <= '0;
      out_bit   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_eq    <= z_c;
      out_bit   <= dec_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_eq) && $stable(out_bit)));
  a_r3_bit_is_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bit == (out_eq >= 0)));
  a_r9_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(hist_bit));
endmodule

// File: tb/sim_dfe_iir_eq.sv
module sim_dfe_iir_eq;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic signed [9:0] in_sample = '0;
  logic signed [7:0] cfg_w1 = '0;
  logic [7:0]        cfg_amp = '0;
  logic [2:0]        cfg_shift = 3'd1;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic signed [11:0] out_eq;
  logic              out_bit;

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  bit finished = 0;
  int m_s, m_eq;
  bit m_d1, m_bit, m_v;

  always #10 clk = ~clk;

  dfe_iir_eq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .cfg_w1(cfg_w1), .cfg_amp(cfg_amp), .cfg_shift(cfg_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_eq(out_eq), .out_bit(out_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int floor_shr(input int x, input int k);
    return x >>> k;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    m_s = 0; m_d1 = 1'b1; m_v = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic cyc(input bit v, input int y, input int w1, input int amp,
                     input int sh, input bit ordy);
    bit acc;
    int k, t, ns;
    in_valid = v; in_sample = y[9:0]; cfg_w1 = w1[7:0];
    cfg_amp = amp[7:0]; cfg_shift = sh[2:0]; out_ready = ordy;
    #1;
    check("R8 in_ready", in_ready, (!m_v || ordy) ? 1 : 0);
    acc = v && in_ready;
    if (acc) begin
      m_eq  = y - (m_d1 ? w1 : -w1) - m_s;
      m_bit = (m_eq >= 0);
      k  = (sh == 0) ? 1 : sh;
      t  = m_d1 ? amp : -amp;
      ns = m_s - floor_shr(m_s, k) + floor_shr(t, k);
      if (ns > 127) ns = 127;
      if (ns < -128) ns = -128;
      m_s = ns; m_d1 = m_bit; m_v = 1'b1;
    end else if (ordy) m_v = 1'b0;
    @(negedge clk);
    check("R7 out_valid", out_valid, m_v);
    if (m_v) begin
      check("R2/R4/R6 out_eq", int'(out_eq), m_eq);
      check("R3 out_bit", out_bit, m_bit);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // first sample uses history +1: 5 - 10 = -5
    cyc(1, 5, 10, 0, 1, 1);
    check("R1 first sample eq", int'(out_eq), -5);
    check("R1 first sample bit", out_bit, 0);

    // tail into saturation, amp 255, shift 1, w1 0
    do_reset();
    cyc(1, 100, 0, 255, 1, 1);
    check("R2 sat seq eq1", int'(out_eq), 100);
    cyc(1, 100, 0, 255, 1, 1);
    check("R4 sat seq eq2", int'(out_eq), -27);
    cyc(1, 100, 0, 255, 1, 1);
    check("R6 saturated state eq3", int'(out_eq), -27);

    // idle cycles with wild configuration must not disturb state (R9)
    for (int i = 0; i < 6; i++) cyc(0, 0, -100, 200, i % 8, 1);
    cyc(1, 0, 0, 0, 1, 1);
    check("R9 state kept across idle", int'(out_eq), 64);

    // decay code 0 behaves as 1 (R5)
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 40 - i * 13, 20, 180, 0, 1);

    // stall: output held while not ready (R8)
    cyc(1, 77, 5, 60, 3, 0);
    for (int i = 0; i < 3; i++) cyc(1, -200, 9, 30, 2, 0);
    cyc(0, 0, 0, 0, 1, 1);

    // constrained random run
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom_range(0, 3) != 0), int'($urandom_range(0, 1023)) - 512,
          int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)),
          int'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0));
      if (i == 1500) do_reset();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      n_cyc++;
      if (n_cyc > 100000 && !finished) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end
endmodule